// File: doc/BRIEF.md
# Exception Entry State Updater

This block records processor state at the moment a fault is taken and chooses the handler vector. When the core raises a fault it presents the faulting program counter, a cause code, an optional faulting virtual address with a valid flag, and its current status word. On that clock edge the block saves the program counter, the cause and the address into the appropriate save registers. It also produces the next status word with the exception-mode bit forced on, and it pulses a one-hot vector select.

A fault that arrives while exception mode is already active counts as nested. It goes to the double-exception vector, and its program counter lands in a dedicated double-exception save register when the configuration provides one. A first-level fault saves into the ordinary first-level register. It then selects the user or kernel vector from the status word's user-mode bit.

Misaligned loads and stores can raise a fault through a separate input. That path produces a fault only when the configuration enables unaligned-access exceptions and has no hardware alignment handling.

Top module: `exc_entry_unit`

## Requirements
- R1: When a fault is taken while bit EXCM_BIT of `ps_i` is 1, the vector select on the following cycle is the double-exception code 3'b100.
- R2: On a nested fault with HAS_DEPC=1, `depc_o` takes the faulting PC and `epc1_o` keeps its value. With HAS_DEPC=0, `epc1_o` takes the faulting PC and `depc_o` stays 0.
- R3: On a fault taken while bit EXCM_BIT of `ps_i` is 0, `epc1_o` takes the faulting PC. The vector is user (3'b001) when bit UM_BIT of `ps_i` is 1 and kernel (3'b010) when it is 0.
- R4: Every taken fault writes its cause into `cause_o`, and `ps_o` becomes `ps_i` with bit EXCM_BIT set.
- R5: `vaddr_o` takes `vaddr_i` on a raise with `vaddr_vld_i`=1 and keeps its value on a raise with `vaddr_vld_i`=0.
- R6: With `raise_i`=0, `misalign_i`=1 takes a fault with cause ALIGN_CAUSE and records `vaddr_i`, but only when UNALIGNED_EXC=1 and HW_ALIGN=0. Otherwise it has no effect. When `raise_i` and `misalign_i` are both 1, the cause is `cause_i`.
- R7: All updates occur on the single rising edge where a fault is taken. `vec_o` is 1-hot (bit 0 user, bit 1 kernel, bit 2 double) for exactly that one cycle and is 0 otherwise.
- R8: A synchronous reset clears `epc1_o`, `depc_o`, `cause_o`, `vaddr_o`, `ps_o` and `vec_o` to 0.
- R9: Save registers that a fault does not select, and all registers when no fault is taken, keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 1 | Fault raise strobe |
| misalign_i | input | 1 | Misaligned load/store detected |
| fault_pc_i | input | PC_W | Faulting program counter |
| cause_i | input | CAUSE_W | Cause code of the raised fault |
| vaddr_i | input | VA_W | Faulting virtual address |
| vaddr_vld_i | input | 1 | `vaddr_i` is meaningful for this raise |
| ps_i | input | PS_W | Current processor status word |
| epc1_o | output | PC_W | First-level exception PC |
| depc_o | output | PC_W | Double-exception PC (0 when not configured) |
| cause_o | output | CAUSE_W | Recorded cause |
| vaddr_o | output | VA_W | Recorded faulting address |
| ps_o | output | PS_W | Status word after exception entry |
| vec_o | output | 3 | One-hot vector select: [0] user, [1] kernel, [2] double |

## Verification
The checker checks on every cycle that the vector select is at most one-hot and pulses only after a taken fault. It also checks that the vector class matches the exception-mode and user-mode bits, that the PC lands in the right save register, and that nothing moves without a fault. Some cases can only be shown by the bench's scenarios: a second configuration without a double-exception register and with hardware alignment, where the misaligned input must be ignored. Another is the stacking of address and cause values over long random sequences that mix nested and first-level faults. A third is the values seen right after reset.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int VEC_W = 3;

   typedef enum logic [VEC_W-1:0] {
      VEC_NONE   = 3'b000,
      VEC_USER   = 3'b001,
      VEC_KERNEL = 3'b010,
      VEC_DOUBLE = 3'b100
   } exc_vec_e;

   typedef struct packed {
      logic     take;
      logic     pc_to_epc1;
      logic     pc_to_depc;
      logic     va_wr;
      exc_vec_e vec;
   } exc_route_t;
endpackage

// File: rtl/exc_align_gate.sv
module exc_align_gate #(
   parameter int CAUSE_W       = 6,
   parameter int ALIGN_CAUSE   = 9,
   parameter bit UNALIGNED_EXC = 1'b1,
   parameter bit HW_ALIGN      = 1'b0
) (
   input  logic               raise_i,
   input  logic               misalign_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic               vaddr_vld_i,
   output logic               take_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               va_wr_o
);
   // misaligned access traps only if software asked for it and no hardware fixup exists
   localparam bit TRAP_EN = UNALIGNED_EXC && !HW_ALIGN;
   localparam logic [CAUSE_W-1:0] ALIGN_CODE = CAUSE_W'(ALIGN_CAUSE);

   logic align_take;

   always_comb begin
      align_take = misalign_i & TRAP_EN;
      take_o     = raise_i | align_take;
      // an explicit raise outranks the alignment path
      cause_o    = raise_i ? cause_i : ALIGN_CODE;
      va_wr_o    = raise_i ? vaddr_vld_i : align_take;
   end
endmodule

// File: rtl/exc_route.sv
module exc_route
   import exc_entry_pkg::*;
#(
   parameter bit HAS_DEPC = 1'b1
) (
   input  logic       take_i,
   input  logic       excm_i,
   input  logic       um_i,
   input  logic       va_wr_i,
   output exc_route_t rt_o
);
   always_comb begin
      rt_o.take       = take_i;
      rt_o.va_wr      = take_i & va_wr_i;
      rt_o.pc_to_depc = take_i & excm_i & HAS_DEPC;
      rt_o.pc_to_epc1 = take_i & ~(excm_i & HAS_DEPC);
      if (!take_i)     rt_o.vec = VEC_NONE;
      else if (excm_i) rt_o.vec = VEC_DOUBLE;
      else if (um_i)   rt_o.vec = VEC_USER;
      else             rt_o.vec = VEC_KERNEL;
   end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
   import exc_entry_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int CAUSE_W  = 6,
   parameter int VA_W     = 32,
   parameter int PS_W     = 32,
   parameter int EXCM_BIT = 4,
   parameter bit HAS_DEPC = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  exc_route_t         rt_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [VA_W-1:0]    vaddr_i,
   input  logic [PS_W-1:0]    ps_i,
   output logic [PC_W-1:0]    epc1_o,
   output logic [PC_W-1:0]    depc_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [VA_W-1:0]    vaddr_o,
   output logic [PS_W-1:0]    ps_o,
   output logic [VEC_W-1:0]   vec_o
);
   localparam logic [PS_W-1:0] EXCM_MASK = PS_W'(1) << EXCM_BIT;

   logic epc1_en;

   generate
      if (HAS_DEPC) begin : g_depc
         logic [PC_W-1:0] depc_q;
         assign epc1_en = rt_i.pc_to_epc1;
         always_ff @(posedge clk) begin
            if (rst)                  depc_q <= '0;
            else if (rt_i.pc_to_depc) depc_q <= pc_i;
         end
         assign depc_o = depc_q;
      end else begin : g_no_depc
         assign epc1_en = rt_i.pc_to_epc1 | rt_i.pc_to_depc;
         assign depc_o  = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         epc1_o  <= '0;
         cause_o <= '0;
         vaddr_o <= '0;
         ps_o    <= '0;
         vec_o   <= '0;
      end else begin
         vec_o <= rt_i.vec;
         if (epc1_en)    epc1_o  <= pc_i;
         if (rt_i.va_wr) vaddr_o <= vaddr_i;
         if (rt_i.take) begin
            cause_o <= cause_i;
            ps_o    <= ps_i | EXCM_MASK;
         end
      end
   end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int PC_W          = 32,
   parameter int CAUSE_W       = 6,
   parameter int VA_W          = 32,
   parameter int PS_W          = 32,
   parameter int EXCM_BIT      = 4,
   parameter int UM_BIT        = 5,
   parameter int ALIGN_CAUSE   = 9,
   parameter bit HAS_DEPC      = 1'b1,
   parameter bit UNALIGNED_EXC = 1'b1,
   parameter bit HW_ALIGN      = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               raise_i,
   input  logic               misalign_i,
   input  logic [PC_W-1:0]    fault_pc_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [VA_W-1:0]    vaddr_i,
   input  logic               vaddr_vld_i,
   input  logic [PS_W-1:0]    ps_i,
   output logic [PC_W-1:0]    epc1_o,
   output logic [PC_W-1:0]    depc_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [VA_W-1:0]    vaddr_o,
   output logic [PS_W-1:0]    ps_o,
   output logic [VEC_W-1:0]   vec_o
);
   generate
      if (EXCM_BIT >= PS_W || UM_BIT >= PS_W || EXCM_BIT == UM_BIT) begin : g_bad_ps
         $error("status bit positions out of range or overlapping");
      end
      if (CAUSE_W < 1 || ALIGN_CAUSE >= (1 << CAUSE_W)) begin : g_bad_cause
         $error("alignment cause does not fit the cause field");
      end
   endgenerate

   logic               take;
   logic               va_wr;
   logic [CAUSE_W-1:0] cause_sel;
   exc_route_t         rt;

   exc_align_gate #(
      .CAUSE_W(CAUSE_W), .ALIGN_CAUSE(ALIGN_CAUSE),
      .UNALIGNED_EXC(UNALIGNED_EXC), .HW_ALIGN(HW_ALIGN)
   ) u_gate (
      .raise_i(raise_i), .misalign_i(misalign_i), .cause_i(cause_i),
      .vaddr_vld_i(vaddr_vld_i), .take_o(take), .cause_o(cause_sel),
      .va_wr_o(va_wr)
   );

   exc_route #(.HAS_DEPC(HAS_DEPC)) u_route (
      .take_i(take), .excm_i(ps_i[EXCM_BIT]), .um_i(ps_i[UM_BIT]),
      .va_wr_i(va_wr), .rt_o(rt)
   );

   exc_state_regs #(
      .PC_W(PC_W), .CAUSE_W(CAUSE_W), .VA_W(VA_W), .PS_W(PS_W),
      .EXCM_BIT(EXCM_BIT), .HAS_DEPC(HAS_DEPC)
   ) u_regs (
      .clk(clk), .rst(rst), .rt_i(rt), .pc_i(fault_pc_i), .cause_i(cause_sel),
      .vaddr_i(vaddr_i), .ps_i(ps_i), .epc1_o(epc1_o), .depc_o(depc_o),
      .cause_o(cause_o), .vaddr_o(vaddr_o), .ps_o(ps_o), .vec_o(vec_o)
   );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int PC_W          = 32,
   parameter int CAUSE_W       = 6,
   parameter int VA_W          = 32,
   parameter int PS_W          = 32,
   parameter int EXCM_BIT      = 4,
   parameter int UM_BIT        = 5,
   parameter bit HAS_DEPC      = 1'b1,
   parameter bit UNALIGNED_EXC = 1'b1,
   parameter bit HW_ALIGN      = 1'b0
) (
   input logic               clk,
   input logic               rst,
   input logic               raise_i,
   input logic               misalign_i,
   input logic [PC_W-1:0]    fault_pc_i,
   input logic [CAUSE_W-1:0] cause_i,
   input logic [VA_W-1:0]    vaddr_i,
   input logic               vaddr_vld_i,
   input logic [PS_W-1:0]    ps_i,
   input logic [PC_W-1:0]    epc1_o,
   input logic [PC_W-1:0]    depc_o,
   input logic [CAUSE_W-1:0] cause_o,
   input logic [VA_W-1:0]    vaddr_o,
   input logic [PS_W-1:0]    ps_o,
   input logic [2:0]         vec_o
);
   localparam bit TRAP = UNALIGNED_EXC && !HW_ALIGN;
   logic take, nest;
   assign take = raise_i | (misalign_i & TRAP);
   assign nest = ps_i[EXCM_BIT];

   a_r1_double_vec: assert property (@(posedge clk) disable iff (rst)
      take && nest |=> vec_o == 3'b100);
   a_r2_depc_pc: assert property (@(posedge clk) disable iff (rst)
      take && nest && HAS_DEPC |=> depc_o == $past(fault_pc_i) && $stable(epc1_o));
   a_r3_epc1_pc: assert property (@(posedge clk) disable iff (rst)
      take && !nest |=> epc1_o == $past(fault_pc_i));
   a_r3_user_vec: assert property (@(posedge clk) disable iff (rst)
      take && !nest && ps_i[UM_BIT] |=> vec_o == 3'b001);
   a_r3_kernel_vec: assert property (@(posedge clk) disable iff (rst)
      take && !nest && !ps_i[UM_BIT] |=> vec_o == 3'b010);
   a_r4_cause: assert property (@(posedge clk) disable iff (rst)
      raise_i |=> cause_o == $past(cause_i) && ps_o[EXCM_BIT]);
   a_r5_vaddr: assert property (@(posedge clk) disable iff (rst)
      raise_i && vaddr_vld_i |=> vaddr_o == $past(vaddr_i));
   a_r6_align_off: assert property (@(posedge clk) disable iff (rst)
      !raise_i && misalign_i && !TRAP |=> vec_o == 3'b000);
   a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(vec_o));
   a_r7_no_pulse: assert property (@(posedge clk) disable iff (rst)
      !take |=> vec_o == 3'b000);
   a_r8_reset: assert property (@(posedge clk)
      rst |=> epc1_o == '0 && depc_o == '0 && cause_o == '0 && vaddr_o == '0
              && ps_o == '0 && vec_o == '0);
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(epc1_o) && $stable(depc_o) && $stable(cause_o)
                && $stable(vaddr_o) && $stable(ps_o));
endmodule

bind exc_entry_unit exc_entry_chk #(
   .PC_W(PC_W), .CAUSE_W(CAUSE_W), .VA_W(VA_W), .PS_W(PS_W),
   .EXCM_BIT(EXCM_BIT), .UM_BIT(UM_BIT), .HAS_DEPC(HAS_DEPC),
   .UNALIGNED_EXC(UNALIGNED_EXC), .HW_ALIGN(HW_ALIGN)
) u_chk (.*);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
   localparam int EXCM = 4, UM = 5, ALC = 9;
   logic clk = 1'b0, rst = 1'b1;
   logic raise, mis, vv;
   logic [31:0] pc, va, ps;
   logic [5:0] cause;
   logic [31:0] epc1[2], depc[2], vad[2], pso[2];
   logic [5:0]  cso[2];
   logic [2:0]  vec[2];
   logic [31:0] e_epc1[2], e_depc[2], e_va[2], e_ps[2], e_cs[2], e_vec[2];
   int total = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   exc_entry_unit i_exc_entry_unit (
      .clk(clk), .rst(rst), .raise_i(raise), .misalign_i(mis), .fault_pc_i(pc),
      .cause_i(cause), .vaddr_i(va), .vaddr_vld_i(vv), .ps_i(ps),
      .epc1_o(epc1[0]), .depc_o(depc[0]), .cause_o(cso[0]), .vaddr_o(vad[0]),
      .ps_o(pso[0]), .vec_o(vec[0]));

   exc_entry_unit #(.HAS_DEPC(1'b0), .HW_ALIGN(1'b1)) i_exc_entry_unit_alt (
      .clk(clk), .rst(rst), .raise_i(raise), .misalign_i(mis), .fault_pc_i(pc),
      .cause_i(cause), .vaddr_i(va), .vaddr_vld_i(vv), .ps_i(ps),
      .epc1_o(epc1[1]), .depc_o(depc[1]), .cause_o(cso[1]), .vaddr_o(vad[1]),
      .ps_o(pso[1]), .vec_o(vec[1]));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference model per instance: k=0 has DEPC and traps misalign, k=1 neither
   task automatic model(int k);
      bit hd = (k == 0), trap = (k == 0);
      bit tk = raise | (mis & trap);
      e_vec[k] = 0;
      if (tk) begin
         if (ps[EXCM]) begin
            e_vec[k] = 32'd4;
            if (hd) e_depc[k] = pc; else e_epc1[k] = pc;
         end else begin
            e_vec[k] = ps[UM] ? 32'd1 : 32'd2;
            e_epc1[k] = pc;
         end
         e_cs[k] = raise ? {26'd0, cause} : ALC;
         if (raise ? vv : 1'b1) e_va[k] = va;
         e_ps[k] = ps | (32'd1 << EXCM);
      end
   endtask

   task automatic compare();
      for (int k = 0; k < 2; k++) begin
         check("R3 epc1", epc1[k], e_epc1[k]);
         check("R2 depc", depc[k], e_depc[k]);
         check("R4 cause", {26'd0, cso[k]}, e_cs[k]);
         check("R5 vaddr", vad[k], e_va[k]);
         check("R4 status", pso[k], e_ps[k]);
         check("R7 vector", {29'd0, vec[k]}, e_vec[k]);
      end
   endtask

   task automatic step(bit r, bit m, logic [31:0] p, logic [5:0] c,
                       logic [31:0] a, bit v, logic [31:0] s);
      raise = r; mis = m; pc = p; cause = c; va = a; vv = v; ps = s;
      model(0); model(1);
      @(posedge clk); #1;
      compare();
      raise = 0; mis = 0;
   endtask

   task automatic idle();
      step(0, 0, $urandom, 6'($urandom), $urandom, 1, $urandom);
   endtask

   initial begin
      void'($urandom(32'd7741));
      raise = 0; mis = 0; pc = 0; cause = 0; va = 0; vv = 0; ps = 0;
      for (int k = 0; k < 2; k++) begin
         e_epc1[k] = 0; e_depc[k] = 0; e_va[k] = 0; e_ps[k] = 0; e_cs[k] = 0; e_vec[k] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      compare();              // R8 reset state
      rst = 0;
      // R3 kernel entry, then R3 user entry
      step(1, 0, 32'h1000_0040, 6'd3, 32'hdead_0000, 1, 32'h0);
      step(1, 0, 32'h2000_0080, 6'd5, 32'hbeef_0000, 0, 32'h1 << UM);
      // R1 nested fault: R2 DEPC on inst 0, EPC1 on inst 1
      step(1, 0, 32'h3000_00c0, 6'd7, 32'h0, 0, (32'h1 << EXCM) | (32'h1 << UM));
      // R9 idle cycle: nothing moves, vector drops
      idle();
      // R6 misalign only: traps on inst 0, ignored on inst 1
      step(0, 1, 32'h4000_0100, 6'd1, 32'h0000_0003, 0, 32'h0);
      // R6 raise and misalign together: explicit cause wins
      step(1, 1, 32'h5000_0140, 6'd12, 32'h0000_0005, 0, 32'h1 << UM);
      // R5 raise without valid address keeps vaddr
      step(1, 0, 32'h6000_0180, 6'd2, 32'hffff_ffff, 0, 32'h0);
      for (int i = 0; i < 400; i++) begin
         if ($urandom % 5 == 0) idle();
         else step($urandom % 2 == 0, $urandom % 4 == 0, $urandom, 6'($urandom),
                   $urandom, $urandom % 2 == 0, $urandom);
      end
      // R8 reset mid-run clears everything
      rst = 1;
      for (int k = 0; k < 2; k++) begin
         e_epc1[k] = 0; e_depc[k] = 0; e_va[k] = 0; e_ps[k] = 0; e_cs[k] = 0; e_vec[k] = 0;
      end
      raise = 1; ps = 32'h1 << EXCM; pc = 32'h1234;
      @(posedge clk); #1;
      compare();
      rst = 0; raise = 0;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule